// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR2 memory interface. It brings the device from power-up to a state where it can accept normal traffic. After reset it holds the clock enable low with the command bus idle. It then raises the clock enable and issues a fixed sequence of commands, with no-operation cycles between them:

- precharge-all;
- four mode-register loads, the fourth of which includes a DLL reset;
- a second precharge-all;
- two auto-refreshes;
- a mode-register reload with the DLL reset cleared;
- an OCD-default load and an OCD-exit load of extended mode register 1.

The gaps between commands are set by parameterized timing counts. One shared down-counter times every wait.

The CAS latency and the write recovery are taken from configuration inputs. They are captured once, when the clock enable rises, and folded into the main mode-register words. After the last load, a DLL lock wait runs. The done flag then rises and stays high, and the bus idles with no-operations. The normal controller then takes over.

Top module: `ddr2_init_seq`

## Requirements
- R1: For the first T_PWRUP cycles after reset, cke_o is low and cs_n_o, ras_n_o, cas_n_o and we_n_o are all high.
- R2: cke_o rises in cycle T_PWRUP and then stays high. The first command is issued T_CKE cycles later.
- R3: Commands are issued in this order: precharge-all, then EMR2, EMR3, EMR1, MR0 with DLL reset, precharge-all, refresh, refresh, MR0, EMR1 with OCD default, and EMR1 with OCD exit. The {ras_n,cas_n,we_n} encodings are precharge 010, refresh 001 and mode load 000, with cs_n low.
- R4: The next command follows each precharge T_RP cycles later, each refresh T_RFC cycles later and each mode load T_MRD cycles later.
- R5: Every cycle after cke_o rises that is not a command cycle is a no-operation: cs_n low and ras_n, cas_n and we_n high.
- R6: The MR0 loads use bank 0. In the word, bits [2:0]=3'b011 (burst of 8), [6:4]=CAS latency, [11:9]=write recovery minus one and bit 8=DLL reset. Bit 8 is set on the first MR0 load and clear on the second. All other bits are zero.
- R7: The EMR1 loads use bank 1 with bit 0 clear (DLL on) and bit 2 set. Bits [9:7] are 3'b000 on the first load, 3'b111 on the OCD-default load and 3'b000 on the OCD-exit load. All other bits are zero.
- R8: The EMR2 and EMR3 loads use banks 2 and 3 with an all-zero address. Both precharges drive address bit 10 high with bank 0.
- R9: done_o is low until T_DLLK cycles after the OCD-exit load, rises then, and stays high.
- R10: cas_lat_i and wr_cyc_i are sampled in the cycle before cke_o rises. Later changes have no effect on the mode words.
- R11: Asserting rst_ni at any point immediately returns the outputs to the R1 state with done_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cas_lat_i | input | 3 | CAS latency for MR0 bits [6:4] |
| wr_cyc_i | input | 4 | Write recovery in cycles (1 to 8) |
| cke_o | output | 1 | Clock enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Address / mode word |
| done_o | output | 1 | Initialization complete |

## Verification
The assertions take for granted that wr_cyc_i lies between 1 and 8 when it is sampled. They also take for granted that every timing parameter is at least 1 and that T_DLLK is at least T_MRD. Outside that range the write-recovery field wraps and the gap arithmetic is no longer meaningful.

The stimulus draws the write recovery from 1 to 8 and the CAS latency from 2 to 7 under a fixed seed. It instantiates the block with legal timing counts. Some runs then scramble both configuration inputs after the capture cycle to show they are ignored. One run cuts the sequence short with a reset.

// File: rtl/ddr2_init_pkg.sv
`timescale 1ns/1ps
package ddr2_init_pkg;

  typedef enum logic [1:0] {CMD_NOP, CMD_PRE, CMD_REF, CMD_MRS} cmd_e;

  typedef enum logic [2:0] {S_PWR, S_CKE, S_CMD, S_GAP, S_DONE} state_e;

  typedef enum logic [3:0] {
    ST_PRE_A, ST_EMR2, ST_EMR3, ST_EMR1_DLL, ST_MR0_RST, ST_PRE_B,
    ST_REF_A, ST_REF_B, ST_MR0_RUN, ST_EMR1_OCD, ST_EMR1_EXIT
  } step_e;

  localparam step_e STEP_LAST = ST_EMR1_EXIT;
  localparam int    MODE_W    = 13;

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // {ras_n, cas_n, we_n}
  function automatic logic [2:0] cmd_pins(cmd_e c);
    case (c)
      CMD_PRE: return 3'b010;
      CMD_REF: return 3'b001;
      CMD_MRS: return 3'b000;
      default: return 3'b111;
    endcase
  endfunction

  function automatic logic [MODE_W-1:0] mr0_word(logic [2:0] cl, logic [2:0] wr_f, logic dll_rst);
    logic [MODE_W-1:0] w;
    w       = '0;
    w[2:0]  = 3'b011;
    w[6:4]  = cl;
    w[8]    = dll_rst;
    w[11:9] = wr_f;
    return w;
  endfunction

  function automatic logic [MODE_W-1:0] emr1_word(logic ocd_dflt);
    logic [MODE_W-1:0] w;
    w      = '0;
    w[2]   = 1'b1;
    w[9:7] = {3{ocd_dflt}};
    return w;
  endfunction

endpackage

// File: rtl/ddr2_init_wait.sv
`timescale 1ns/1ps
module ddr2_init_wait #(
  parameter int CNT_W   = 8,
  parameter int RST_VAL = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= CNT_W'(RST_VAL);
    else if (load_i)       cnt_q <= load_val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  // R4
  wait_park_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (zero_o && !load_i) |=> zero_o);

endmodule

// File: rtl/ddr2_init_rom.sv
`timescale 1ns/1ps
module ddr2_init_rom
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int BA_W   = 3,
  parameter int CNT_W  = 8,
  parameter int T_RP   = 3,
  parameter int T_MRD  = 2,
  parameter int T_RFC  = 9,
  parameter int T_DLLK = 200
) (
  input  step_e             step_i,
  input  logic [2:0]        cl_i,
  input  logic [2:0]        wr_f_i,
  output cmd_e              cmd_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  gap_o
);

  logic [MODE_W-1:0] word;

  always_comb begin
    cmd_o = CMD_MRS;
    ba_o  = '0;
    word  = '0;
    gap_o = CNT_W'(T_MRD);
    case (step_i)
      ST_PRE_A, ST_PRE_B: begin
        cmd_o    = CMD_PRE;
        word[10] = 1'b1;
        gap_o    = CNT_W'(T_RP);
      end
      ST_REF_A, ST_REF_B: begin
        cmd_o = CMD_REF;
        gap_o = CNT_W'(T_RFC);
      end
      ST_EMR2:     ba_o = BA_W'(2);
      ST_EMR3:     ba_o = BA_W'(3);
      ST_EMR1_DLL: begin ba_o = BA_W'(1); word = emr1_word(1'b0); end
      ST_EMR1_OCD: begin ba_o = BA_W'(1); word = emr1_word(1'b1); end
      ST_EMR1_EXIT: begin
        ba_o  = BA_W'(1);
        word  = emr1_word(1'b0);
        gap_o = CNT_W'(T_DLLK);   // DLL lock wait closes the sequence
      end
      ST_MR0_RST:  word = mr0_word(cl_i, wr_f_i, 1'b1);
      ST_MR0_RUN:  word = mr0_word(cl_i, wr_f_i, 1'b0);
      default:     cmd_o = CMD_NOP;
    endcase
  end

  always_comb begin
    addr_o             = '0;
    addr_o[MODE_W-1:0] = word;
  end

endmodule

// File: rtl/ddr2_init_ctrl.sv
`timescale 1ns/1ps
module ddr2_init_ctrl
  import ddr2_init_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int T_CKE = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       cas_lat_i,
  input  logic [3:0]       wr_cyc_i,
  input  logic             zero_i,
  input  logic [CNT_W-1:0] gap_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output state_e           state_o,
  output step_e            step_o,
  output logic [2:0]       cl_o,
  output logic [2:0]       wr_f_o
);

  state_e     state_q, state_d;
  step_e      step_q, step_d;
  logic [2:0] cl_q, wr_f_q;
  logic       adv;

  always_comb begin
    state_d    = state_q;
    step_d     = step_q;
    load_o     = 1'b0;
    load_val_o = '0;
    adv        = 1'b0;
    case (state_q)
      S_PWR: if (zero_i) begin
        state_d    = S_CKE;
        load_o     = 1'b1;
        load_val_o = CNT_W'(T_CKE - 1);
      end
      S_CKE: if (zero_i) state_d = S_CMD;
      S_CMD: begin
        if (gap_i > CNT_W'(1)) begin
          state_d    = S_GAP;
          load_o     = 1'b1;
          load_val_o = gap_i - CNT_W'(2);
        end else begin
          adv = 1'b1;
        end
      end
      S_GAP:   adv = zero_i;
      default: ;
    endcase
    if (adv) begin
      if (step_q == STEP_LAST) begin
        state_d = S_DONE;
      end else begin
        state_d = S_CMD;
        step_d  = step_e'(step_q + 4'd1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_PWR;
      step_q  <= ST_PRE_A;
      cl_q    <= '0;
      wr_f_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      if (state_q == S_PWR && zero_i) begin
        cl_q   <= cas_lat_i;
        wr_f_q <= 3'(wr_cyc_i - 4'd1);
      end
    end
  end

  assign state_o = state_q;
  assign step_o  = step_q;
  assign cl_o    = cl_q;
  assign wr_f_o  = wr_f_q;

  // R3
  step_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_q != $past(step_q)) |-> (step_q == step_e'($past(step_q) + 4'd1)));

  // R10
  cfg_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != S_PWR) |=> ($stable(cl_q) && $stable(wr_f_q)));

  // R9
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_DONE) |=> (state_q == S_DONE));

endmodule

// File: rtl/ddr2_init_seq.sv
`timescale 1ns/1ps
module ddr2_init_seq
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W  = 14,
  parameter int BA_W    = 3,
  parameter int T_PWRUP = 64,
  parameter int T_CKE   = 4,
  parameter int T_RP    = 3,
  parameter int T_MRD   = 2,
  parameter int T_RFC   = 26,
  parameter int T_DLLK  = 200
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        cas_lat_i,
  input  logic [3:0]        wr_cyc_i,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);

  localparam int T_MAX = max2(max2(max2(T_PWRUP, T_CKE), max2(T_RP, T_MRD)),
                              max2(T_RFC, T_DLLK));
  localparam int CNT_W = $clog2(T_MAX + 1);

  state_e            state;
  step_e             step;
  cmd_e              rom_cmd;
  logic [BA_W-1:0]   rom_ba;
  logic [ADDR_W-1:0] rom_addr;
  logic [CNT_W-1:0]  gap, load_val;
  logic              load, zero;
  logic [2:0]        cl, wr_f;

  ddr2_init_ctrl #(.CNT_W(CNT_W), .T_CKE(T_CKE)) i_ctrl (
    .clk_i, .rst_ni, .cas_lat_i, .wr_cyc_i,
    .zero_i(zero), .gap_i(gap), .load_o(load), .load_val_o(load_val),
    .state_o(state), .step_o(step), .cl_o(cl), .wr_f_o(wr_f)
  );

  ddr2_init_wait #(.CNT_W(CNT_W), .RST_VAL(T_PWRUP - 1)) i_wait (
    .clk_i, .rst_ni, .load_i(load), .load_val_i(load_val), .zero_o(zero)
  );

  ddr2_init_rom #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .CNT_W(CNT_W),
    .T_RP(T_RP), .T_MRD(T_MRD), .T_RFC(T_RFC), .T_DLLK(T_DLLK)
  ) i_rom (
    .step_i(step), .cl_i(cl), .wr_f_i(wr_f),
    .cmd_o(rom_cmd), .ba_o(rom_ba), .addr_o(rom_addr), .gap_o(gap)
  );

  always_comb begin
    cke_o                       = (state != S_PWR);
    {cs_n_o, ras_n_o, cas_n_o, we_n_o} = 4'b1111;
    ba_o                        = '0;
    addr_o                      = '0;
    if (state != S_PWR) begin
      cs_n_o = 1'b0;
      if (state == S_CMD) begin
        {ras_n_o, cas_n_o, we_n_o} = cmd_pins(rom_cmd);
        ba_o   = rom_ba;
        addr_o = rom_addr;
      end
    end
  end

  assign done_o = (state == S_DONE);

  // R1
  pwr_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cke_o |-> (cs_n_o && ras_n_o && cas_n_o && we_n_o && !done_o));

  // R2
  cke_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(cke_o));

  // R5
  nop_fill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cke_o && state != S_CMD) |-> (!cs_n_o && ras_n_o && cas_n_o && we_n_o));

  // R6
  mr0_burst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_o && !ras_n_o && !cas_n_o && !we_n_o && ba_o == '0) |-> (addr_o[2:0] == 3'b011));

  // R9
  done_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cke_o && !cs_n_o && ras_n_o && cas_n_o && we_n_o));

endmodule

// File: tb/test_ddr2_init_seq.sv
`timescale 1ns/1ps
module test_ddr2_init_seq;

  localparam int ADDR_W  = 14;
  localparam int BA_W    = 3;
  localparam int T_PWRUP = 12;
  localparam int T_CKE   = 4;
  localparam int T_RP    = 3;
  localparam int T_MRD   = 2;
  localparam int T_RFC   = 9;
  localparam int T_DLLK  = 200;
  localparam int NCMD    = 11;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic [2:0]        cas_lat_i = 3'd3;
  logic [3:0]        wr_cyc_i = 4'd3;
  logic              cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, done_o;
  logic [BA_W-1:0]   ba_o;
  logic [ADDR_W-1:0] addr_o;

  always #2.5 clk = ~clk;

  ddr2_init_seq #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .T_PWRUP(T_PWRUP), .T_CKE(T_CKE),
    .T_RP(T_RP), .T_MRD(T_MRD), .T_RFC(T_RFC), .T_DLLK(T_DLLK)
  ) i_ddr2_init_seq (
    .clk_i(clk), .rst_ni, .cas_lat_i, .wr_cyc_i,
    .cke_o, .cs_n_o, .ras_n_o, .cas_n_o, .we_n_o, .ba_o, .addr_o, .done_o
  );

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  logic [2:0]        e_pins [NCMD];
  logic [BA_W-1:0]   e_ba   [NCMD];
  logic [ADDR_W-1:0] e_addr [NCMD];
  int                e_cyc  [NCMD];
  string             e_req  [NCMD];
  int                e_done;

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] f_mr0(int cl, int wr, bit dll);
    logic [ADDR_W-1:0] w = '0;
    w = ADDR_W'(3) | ADDR_W'(cl << 4) | ADDR_W'(((wr - 1) & 7) << 9);
    if (dll) w[8] = 1'b1;
    return w;
  endfunction

  function automatic logic [ADDR_W-1:0] f_emr1(bit ocd);
    return ocd ? ADDR_W'(14'h0384) : ADDR_W'(14'h0004);
  endfunction

  task automatic build(int cl, int wr);
    int cyc = T_PWRUP + T_CKE;
    int gap [NCMD] = '{T_RP, T_MRD, T_MRD, T_MRD, T_MRD, T_RP, T_RFC, T_RFC, T_MRD, T_MRD, T_DLLK};
    e_pins = '{3'b010, 3'b000, 3'b000, 3'b000, 3'b000, 3'b010, 3'b001, 3'b001, 3'b000, 3'b000, 3'b000};
    e_ba   = '{0, 2, 3, 1, 0, 0, 0, 0, 0, 1, 1};
    e_addr = '{ADDR_W'(14'h0400), '0, '0, f_emr1(0), f_mr0(cl, wr, 1), ADDR_W'(14'h0400),
               '0, '0, f_mr0(cl, wr, 0), f_emr1(1), f_emr1(0)};
    e_req  = '{"R8", "R8", "R8", "R7", "R6", "R8", "R3", "R3", "R6", "R7", "R7"};
    for (int i = 0; i < NCMD; i++) begin
      e_cyc[i] = cyc;
      cyc += gap[i];
    end
    e_done = cyc;
  endtask

  task automatic run(int cl, int wr, bit perturb, int stop_at);
    int idx = 0;
    rst_ni    = 1'b0;
    cas_lat_i = 3'(cl);
    wr_cyc_i  = 4'(wr);
    build(cl, wr);
    repeat (2) @(negedge clk);
    chk({cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, done_o} == 6'b011110, "R1 reset",
        {cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, done_o}, 6'b011110);
    rst_ni = 1'b1;
    for (int n = 0; n <= e_done + 3; n++) begin
      if (stop_at > 0 && n == stop_at) begin
        rst_ni = 1'b0;
        #1;
        // R11: reset mid-sequence returns to idle power-up state
        chk({cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, done_o} == 6'b011110, "R11",
            {cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, done_o}, 6'b011110);
        return;
      end
      chk(done_o == (n >= e_done), "R9", done_o, n >= e_done);
      if (n < T_PWRUP) begin
        chk({cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o} == 5'b01111, "R1",
            {cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o}, 5'b01111);
      end else begin
        chk(cke_o == 1'b1, "R2", cke_o, 1);
        if (idx < NCMD && n == e_cyc[idx]) begin
          chk({cs_n_o, ras_n_o, cas_n_o, we_n_o} == {1'b0, e_pins[idx]}, "R3 R4 command",
              {cs_n_o, ras_n_o, cas_n_o, we_n_o}, {1'b0, e_pins[idx]});
          chk(ba_o == e_ba[idx], e_req[idx], ba_o, e_ba[idx]);
          if (e_pins[idx] != 3'b001)
            chk(addr_o == e_addr[idx], e_req[idx], addr_o, e_addr[idx]);
          idx++;
        end else begin
          chk({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0111, "R5",
              {cs_n_o, ras_n_o, cas_n_o, we_n_o}, 4'b0111);
        end
      end
      // R10: scramble configuration after the capture edge
      if (perturb && n >= T_PWRUP) begin
        cas_lat_i = 3'($urandom);
        wr_cyc_i  = 4'($urandom);
      end
      @(negedge clk);
    end
    chk(idx == NCMD, "R3 count", idx, NCMD);
  endtask

  initial begin
    void'($urandom(32'h00c0ffee));
    run(3, 3, 1'b0, 0);
    run(7, 8, 1'b1, 0);   // R6 extreme fields, R10 perturbed
    run(2, 1, 1'b0, 0);
    run(5, 4, 1'b0, 40);  // R11 abort mid-sequence
    run(5, 4, 1'b1, 0);
    for (int k = 0; k < 6; k++)
      run(2 + int'($urandom % 6), 1 + int'($urandom % 8), 1'($urandom), 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule